// File: doc/BRIEF.md
# Interrupt Source PQ Coalescing Array

This block holds a bank of interrupt sources. Each source carries two state bits: P, set while an event for the source sits in the downstream event queue awaiting end-of-interrupt, and Q, set when a further trigger arrives while P is already set. Repeated triggers therefore merge, and a source has at most one event outstanding in the queue at any time. When an end-of-interrupt finds Q set, the source is triggered again.

Hardware triggers arrive on one pulse input per source. Software reaches the state through a load/store port. The port carries a source index and an offset within that source's page, and the offset selects the operation. Every load returns the source's state as it was before the operation, and the read and the update happen in the same cycle. Some sources also accept end-of-interrupt by a store, and some accept a software trigger by a store to a separate trigger page. Parameter masks enable these two options per source. Notifications wait in a per-source pending flag until the downstream valid/ready handshake takes them. Pending sources are served in round-robin order.

Top module: `pq_coalesce_array`

## Requirements
- R1: After reset every source holds PQ=01, ntf_valid is low and rsp_valid is low.
- R2: A trigger on PQ=00 moves the source to 10 and raises one notification. A trigger on 10 moves it to 11 with no notification. A trigger on 11 leaves 11 with no notification.
- R3: A trigger on a source at PQ=01 (masked) leaves it at 01 and raises no notification.
- R4: A load at offset 0x000 is an end-of-interrupt and returns the old state. 10 becomes 00. 11 becomes 10 and raises a notification. 00 and 01 are left unchanged.
- R5: A load at offset 0x800 returns the state and leaves it unchanged.
- R6: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 respectively, and return the old state.
- R7: Each load gives rsp_valid exactly one cycle later. rsp_data holds P in bit 1 and Q in bit 0, with all higher bits zero.
- R8: A store at offset 0x400 (with mmio_trig_page low) is an end-of-interrupt only for sources whose bit in STORE_EOI_MASK is set. For other sources it has no effect.
- R9: A store with mmio_trig_page high acts as a trigger only for sources whose bit in SWTRIG_MASK is set. For other sources it has no effect. A load with mmio_trig_page high returns zero.
- R10: A load at any other offset returns zero and changes nothing. A store at any offset other than 0x400 on the state page changes nothing.
- R11: When an MMIO operation and a hardware trigger hit the same source in the same cycle, the MMIO operation is applied first and the trigger second. The load returns the state from before both.
- R12: ntf_valid stays high until ntf_ready accepts it. A source is never pending twice. Pending sources are served in round-robin order, starting after the last source served, and source 0 comes first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NSRC | Hardware trigger pulse, one bit per source |
| mmio_valid | input | 1 | MMIO access request |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_trig_page | input | 1 | Access targets the software-trigger page |
| mmio_src | input | IW | Source index |
| mmio_off | input | OFFW | Offset within the page |
| rsp_valid | output | 1 | Load data valid, one cycle after the load |
| rsp_data | output | DW | Previous PQ state, P in bit 1 and Q in bit 0 |
| ntf_valid | output | 1 | Notification available |
| ntf_idx | output | IW | Index of the source being notified |
| ntf_ready | input | 1 | Downstream accepts the notification |

## Verification
A hardware trigger and an MMIO operation on the same source can land in the same cycle. So can a notification being accepted and the same source raising a new notification. The bench raises both collisions in directed cases, such as an end-of-interrupt at 11 together with a trigger, and an accept together with a re-notification. It also raises them through random stimulus that aims triggers and loads at a small set of sources while ntf_ready toggles. Each result is judged against a bench model that applies the MMIO operation first, then the trigger, then the accept. Later state reads and the served notification indices are compared with that model.

// File: rtl/pq_coalesce_array.sv
module pq_coalesce_array #(
  parameter int NSRC = 8,
  parameter int OFFW = 12,
  parameter int DW = 64,
  parameter logic [NSRC-1:0] STORE_EOI_MASK = 8'h0F,
  parameter logic [NSRC-1:0] SWTRIG_MASK = 8'h33,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trig_i,
  input  logic            mmio_valid,
  input  logic            mmio_write,
  input  logic            mmio_trig_page,
  input  logic [IW-1:0]   mmio_src,
  input  logic [OFFW-1:0] mmio_off,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            ntf_valid,
  output logic [IW-1:0]   ntf_idx,
  input  logic            ntf_ready
);

  logic [1:0]      pq   [NSRC];
  logic [1:0]      pq_n [NSRC];
  logic [NSRC-1:0] pend, emit, clr;
  logic [IW-1:0]   ptr, pick;
  logic            ld, st, op_eoi, op_rd, op_set, op_swt, ld_hit, hs;
  logic [1:0]      setv;

  assign ld     = mmio_valid & ~mmio_write & ~mmio_trig_page;
  assign st     = mmio_valid & mmio_write;
  assign op_rd  = ld && mmio_off == OFFW'(12'h800);
  assign op_set = ld && mmio_off[OFFW-1 -: 2] == 2'b11 && mmio_off[OFFW-5:0] == '0;
  assign setv   = mmio_off[OFFW-3 -: 2];
  assign op_eoi = (ld && mmio_off == '0) ||
                  (st && !mmio_trig_page && mmio_off == OFFW'(12'h400) && STORE_EOI_MASK[mmio_src]);
  assign op_swt = st && mmio_trig_page && SWTRIG_MASK[mmio_src];
  assign ld_hit = ld && (mmio_off == '0 || op_rd || op_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= mmio_valid & ~mmio_write;
      rsp_data  <= ld_hit ? DW'(pq[mmio_src]) : '0;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic       sel, ea, eb;
    logic [1:0] mid;
    assign sel = mmio_valid && mmio_src == IW'(i);

    always_comb begin
      mid = pq[i];
      ea  = 1'b0;
      if (sel && op_eoi) begin
        if (pq[i] == 2'b10) mid = 2'b00;
        else if (pq[i] == 2'b11) begin
          mid = 2'b10;
          ea  = 1'b1;
        end
      end else if (sel && op_set) begin
        mid = setv;
      end
      pq_n[i] = mid;
      eb      = 1'b0;
      if (trig_i[i] || (sel && op_swt)) begin
        if (mid == 2'b00) begin
          pq_n[i] = 2'b10;
          eb      = 1'b1;
        end else if (mid == 2'b10) begin
          pq_n[i] = 2'b11;
        end
      end
      emit[i] = ea | eb;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pq[i] <= 2'b01;
      else        pq[i] <= pq_n[i];
    end

    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pq[i] == 2'b01 && trig_i[i] && !sel) |=> (pq[i] == 2'b01));
    p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pq[i] == 2'b00 && trig_i[i] && !sel) |=> (pq[i] == 2'b10 && pend[i]));
    p_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pq[i][1] && trig_i[i] && !sel) |=> (pq[i] == 2'b11));
  end

  always_comb begin
    pick = ptr;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pend[(int'(ptr) + k) % NSRC]) pick = IW'((int'(ptr) + k) % NSRC);
    end
  end

  assign ntf_valid = |pend;
  assign ntf_idx   = pick;
  assign hs        = ntf_valid & ntf_ready;
  assign clr       = hs ? (NSRC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ptr  <= '0;
    end else begin
      pend <= (pend & ~clr) | emit;
      if (hs) ptr <= (pick == IW'(NSRC - 1)) ? '0 : pick + 1'b1;
    end
  end

  p_rsp_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DW-1:2] == '0));
  p_rsp_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && !mmio_write) |=> rsp_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> ntf_valid);

endmodule

// File: tb/pq_coalesce_array_tb.sv
module pq_coalesce_array_tb;
  localparam int N = 8;
  localparam logic [N-1:0] SEOI = 8'h0F;
  localparam logic [N-1:0] STRG = 8'h33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] trig_i = '0;
  logic mmio_valid = 0, mmio_write = 0, mmio_trig_page = 0, ntf_ready = 0;
  logic [2:0] mmio_src = '0;
  logic [11:0] mmio_off = '0;
  logic rsp_valid, ntf_valid;
  logic [63:0] rsp_data;
  logic [2:0] ntf_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] mpq [N];
  logic [N-1:0] mpend = '0;
  logic served = 0;
  logic [2:0] served_idx = '0;

  pq_coalesce_array u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mmio_valid(mmio_valid),
    .mmio_write(mmio_write), .mmio_trig_page(mmio_trig_page), .mmio_src(mmio_src),
    .mmio_off(mmio_off), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ntf_valid(ntf_valid), .ntf_idx(ntf_idx), .ntf_ready(ntf_ready));

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] f_trig(logic [1:0] s);
    if (s == 2'b00) return 3'b110;
    if (s == 2'b10) return 3'b011;
    return {1'b0, s};
  endfunction

  function automatic logic [2:0] f_eoi(logic [1:0] s);
    if (s == 2'b10) return 3'b000;
    if (s == 2'b11) return 3'b110;
    return {1'b0, s};
  endfunction

  task automatic step(logic [N-1:0] tr, logic v, logic w, logic tp, int src,
                      logic [11:0] off, logic rdy, string tag);
    logic [N-1:0] em, clr;
    logic [1:0] mid;
    logic [2:0] r;
    logic [63:0] ed;
    logic ev, e, tsw;
    em = '0; clr = '0; ed = '0; ev = v && !w; tsw = 0;
    trig_i = tr; mmio_valid = v; mmio_write = w; mmio_trig_page = tp;
    mmio_src = 3'(src); mmio_off = off; ntf_ready = rdy;
    for (int i = 0; i < N; i++) begin
      mid = mpq[i]; e = 0;
      if (v && i == src) begin
        if (!w && !tp && (off == 12'h000 || off == 12'h800 || (off[11:10] == 2'b11 && off[7:0] == 0)))
          ed = 64'(mpq[i]);
        if ((!w && !tp && off == 12'h000) || (w && !tp && off == 12'h400 && SEOI[i])) begin
          r = f_eoi(mid); mid = r[1:0]; e = r[2];
        end else if (!w && !tp && off[11:10] == 2'b11 && off[7:0] == 0) begin
          mid = off[9:8];
        end
        tsw = w && tp && STRG[i];
      end else tsw = 0;
      if (tr[i] || tsw) begin
        r = f_trig(mid); mid = r[1:0]; e = e | r[2];
      end
      mpq[i] = mid; em[i] = e;
    end
    served = 0;
    if (ntf_valid && rdy) begin
      chk("R12 served source is pending", 64'(mpend[ntf_idx]), 64'd1);
      clr[ntf_idx] = 1'b1;
      served = 1; served_idx = ntf_idx;
    end
    @(posedge clk);
    mpend = (mpend & ~clr) | em;
    @(negedge clk);
    trig_i = '0; mmio_valid = 0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(ev));
    if (ev) chk({tag, " R7 data"}, rsp_data, ed);
    chk("R12 ntf_valid", 64'(ntf_valid), 64'(|mpend));
  endtask

  task automatic ld(int src, logic [11:0] off, string tag);
    step('0, 1, 0, 0, src, off, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < N; i++) mpq[i] = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 ntf_valid after reset", 64'(ntf_valid), 0);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 0);
    ld(0, 12'h800, "R1 read");
    chk("R1 reset PQ literal", rsp_data, 64'h1);
    step(8'h04, 0, 0, 0, 0, 0, 0, "R3");
    ld(2, 12'h800, "R3 masked read");
    chk("R3 masked stays 01", rsp_data, 64'h1);
    for (int i = 0; i < N; i++) ld(i, 12'hC00, "R6 set00");
    step('1, 0, 0, 0, 0, 0, 0, "R2 trigger all");
    step('1, 0, 0, 0, 0, 0, 0, "R2 merge");
    ld(4, 12'h800, "R5 read");
    chk("R2 merged to 11", rsp_data, 64'h3);
    for (int k = 0; k < N; k++) begin
      step('0, 0, 0, 0, 0, 0, 1, "R12 drain");
      chk("R12 round-robin order", 64'(served_idx), 64'(k));
    end
    ld(3, 12'h000, "R4 eoi 11");
    chk("R4 eoi returns 11", rsp_data, 64'h3);
    step('0, 0, 0, 0, 0, 0, 1, "R4 renotify");
    chk("R4 renotify idx", 64'(served_idx), 64'd3);
    step('0, 1, 1, 0, 5, 12'h400, 0, "R8 store eoi masked-off");
    ld(5, 12'h800, "R8 read");
    chk("R8 unchanged 11", rsp_data, 64'h3);
    step('0, 1, 1, 0, 1, 12'h400, 0, "R8 store eoi enabled");
    ld(1, 12'h800, "R8 read");
    chk("R8 11 to 10", rsp_data, 64'h2);
    ld(0, 12'h100, "R10 unused");
    chk("R10 unused returns 0", rsp_data, 0);
    ld(6, 12'hC00, "R6 set00");
    step('0, 1, 1, 1, 6, 0, 0, "R9 swtrig disabled");
    ld(6, 12'h800, "R9 read");
    chk("R9 no trigger on 6", rsp_data, 0);
    ld(0, 12'hC00, "R6 set00");
    step('0, 1, 1, 1, 0, 0, 0, "R9 swtrig enabled");
    ld(0, 12'h800, "R9 read");
    chk("R9 trigger to 10", rsp_data, 64'h2);
    step('0, 1, 0, 1, 0, 0, 0, "R9 trig page load");
    chk("R9 trig page load zero", rsp_data, 0);
    ld(7, 12'hF00, "R6 set11");
    step(8'h80, 1, 0, 0, 7, 12'h000, 0, "R11 eoi+trigger");
    chk("R11 returns pre-state", rsp_data, 64'h3);
    ld(7, 12'h800, "R11 read");
    chk("R11 ends at 11", rsp_data, 64'h3);
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] offs [9];
      logic [11:0] o;
      logic w, tp;
      string tg;
      offs = '{12'h000, 12'h400, 12'h800, 12'hC00, 12'hD00, 12'hE00, 12'hF00, 12'h100, 12'h7F8};
      o = offs[$urandom % 9];
      w = ($urandom % 4) == 0;
      tp = ($urandom % 8) == 0;
      if (tp) tg = "R9 random";
      else if (w) tg = (o == 12'h400) ? "R8 random" : "R10 random store";
      else if (o == 12'h000) tg = "R4 random";
      else if (o == 12'h800) tg = "R5 random";
      else if (o[11:10] == 2'b11) tg = "R6 random";
      else tg = "R10 random";
      step(N'($urandom & $urandom), ($urandom % 3) != 0, w, tp, $urandom % 4, o,
           1'($urandom), {tg, " R11"});
    end
    for (int i = 0; i < N; i++) ld(i, 12'h800, "R5 final read");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule